// File: doc/BRIEF.md
# Middle-Level Cache Line Coherence Updater

This block keeps the coherence status and the data of a single line in a cache that sits between an upper-level cache and a lower level of memory. Three kinds of traffic reach it. Requests come from the upper cache: reads, exclusive reads, writes and upgrades. Fills return from below. Writebacks arrive from above. For each strobed request the block works out, in the same cycle, whether this level can satisfy it. It also decides whether a response must go back, whether the requester has to be told that its copy is shared, and what the line status becomes. The new status and any new data are registered on the following clock edge.

The line here does not behave like a plain write-invalidate or MESI line. When the upper cache takes a whole block, this level either demotes its own copy to read-only or gives it up altogether. When a writeback lands on a read-only copy, this level becomes the owner (dirty) but does not gain write permission. Tag lookup, replacement and miss handling are left to the surrounding cache. The data array is reduced to one register per line, written under the block's own control.

Top module: `coh_line_updater`

## Requirements
- R1: An exclusive read (`req_cmd`=1) with `req_full`=1 that hits a valid, writable line is satisfied and leaves the line invalid (status 000).
- R2: A read (`req_cmd`=0) with `req_full`=1 that hits a valid line is satisfied and raises `shared_out`. The line stays valid with writable cleared and dirty unchanged. `shared_out` is never raised for any other request.
- R3: An upgrade (`req_cmd`=3) that hits a valid, writable line is satisfied and leaves the line invalid.
- R4: A writeback (`req_cmd`=4) with `req_full`=1 to a valid line is satisfied. It replaces the line data with `req_data` and sets dirty without changing the writable bit, so a read-only line stays read-only.
- R5: `resp_req` is 1 only for a satisfied request with `req_needs_resp`=1 whose code is neither writeback (4) nor fill (5). A writeback never produces a response.
- R6: A fill (`req_cmd`=5) always loads `req_data` and makes the line valid. The line is also writable when `fill_excl`=1 or `fill_shared`=0. Dirty after a fill equals dirty before it if the line was valid, and is 0 if the line was invalid.
- R7: A writeback with `req_full`=0 is unsatisfied and leaves status and data unchanged.
- R8: A request is unsatisfied, and leaves status and data unchanged, in these cases: any non-fill request to an invalid line; an exclusive read, write (`req_cmd`=2) or upgrade to a non-writable line; any code 6 or 7.
- R9: Status bits are valid=bit0, writable=bit1, dirty=bit2. An invalid line always reads back as 000.
- R10: `sat`, `resp_req`, `shared_out` and `nxt_stat` reflect the request in the cycle `req_valid` is high. `line_stat` and `line_data` change only on the next clock edge. With `req_valid`=0, nothing changes and all three flags are 0.
- R11: A read or exclusive read with `req_full`=0 that hits is satisfied and leaves the status unchanged. A write that hits a writable line replaces the data and sets dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the line |
| req_valid | input | 1 | Request strobe |
| req_cmd | input | 3 | 0 read, 1 exclusive read, 2 write, 3 upgrade, 4 writeback, 5 fill |
| req_full | input | 1 | Request covers one whole block |
| req_needs_resp | input | 1 | Requester expects a response |
| fill_excl | input | 1 | Fill answers a request that needed exclusivity |
| fill_shared | input | 1 | Another cache asserted shared on the fill |
| req_data | input | BLK_W | Block or write data |
| sat | output | 1 | Request satisfied at this level |
| resp_req | output | 1 | A response must be returned |
| shared_out | output | 1 | Shared asserted toward the requester |
| nxt_stat | output | 3 | Status the line takes at the next edge |
| line_stat | output | 3 | Registered line status |
| line_data | output | BLK_W | Registered line data |

## Verification
The bench drives the line through read-only, writable and dirty states and targets each transition with a distinct status pattern. A design that kept write permission on a full read would show 011 or 111 where 001 or 101 is expected. One that let a writeback grant write permission would show 111 after a writeback to 001. One that answered writebacks would raise `resp_req` with `req_needs_resp` set. Fills are tried on both valid dirty and invalid lines, so a fill that invents or drops dirty is exposed. Partial writebacks, permission misses and the unused codes are checked to leave status and data untouched.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [2:0] {
        CMD_RD   = 3'd0,
        CMD_RDX  = 3'd1,
        CMD_WR   = 3'd2,
        CMD_UPG  = 3'd3,
        CMD_WB   = 3'd4,
        CMD_FILL = 3'd5
    } coh_cmd_e;

    // bit0 valid, bit1 writable, bit2 dirty
    typedef struct packed {
        logic dirty;
        logic wr;
        logic vld;
    } line_stat_t;

    localparam int STAT_W = $bits(line_stat_t);

endpackage

// File: rtl/coh_perm_chk.sv
module coh_perm_chk
    import coh_pkg::*;
(
    input  coh_cmd_e   cmd_i,
    input  line_stat_t stat_i,
    input  logic       full_i,
    output logic       sat_o
);

    always_comb begin
        sat_o = 1'b0;
        case (cmd_i)
            CMD_RD:   sat_o = stat_i.vld;
            CMD_RDX,
            CMD_WR,
            CMD_UPG:  sat_o = stat_i.vld & stat_i.wr;
            CMD_WB:   sat_o = stat_i.vld & full_i;
            CMD_FILL: sat_o = 1'b1;
            default:  sat_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/coh_fill_state.sv
module coh_fill_state
    import coh_pkg::*;
(
    input  line_stat_t stat_i,
    input  logic       excl_i,
    input  logic       shared_i,
    output line_stat_t stat_o
);

    always_comb begin
        stat_o.vld   = 1'b1;
        stat_o.wr    = excl_i | ~shared_i;
        stat_o.dirty = stat_i.vld & stat_i.dirty;
    end

endmodule

// File: rtl/coh_line_updater.sv
module coh_line_updater
    import coh_pkg::*;
#(
    parameter int BLK_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic              req_full,
    input  logic              req_needs_resp,
    input  logic              fill_excl,
    input  logic              fill_shared,
    input  logic [BLK_W-1:0]  req_data,
    output logic              sat,
    output logic              resp_req,
    output logic              shared_out,
    output logic [STAT_W-1:0] nxt_stat,
    output logic [STAT_W-1:0] line_stat,
    output logic [BLK_W-1:0]  line_data
);

    typedef struct packed {
        line_stat_t       stat;
        logic [BLK_W-1:0] data;
    } line_t;

    typedef struct packed {
        logic sat;
        logic resp;
        logic shr;
    } flags_t;

    line_t      line_d, line_q;
    flags_t     flags_d;
    coh_cmd_e   cmd;
    logic       perm_sat;
    line_stat_t fill_stat;

    assign cmd = coh_cmd_e'(req_cmd);

    coh_perm_chk u_perm (
        .cmd_i  (cmd),
        .stat_i (line_q.stat),
        .full_i (req_full),
        .sat_o  (perm_sat)
    );

    coh_fill_state u_fill (
        .stat_i   (line_q.stat),
        .excl_i   (fill_excl),
        .shared_i (fill_shared),
        .stat_o   (fill_stat)
    );

    always_comb begin
        line_d  = line_q;
        flags_d = '0;
        if (req_valid && perm_sat) begin
            flags_d.sat = 1'b1;
            case (cmd)
                CMD_RD: begin
                    if (req_full) begin
                        flags_d.shr    = 1'b1;
                        line_d.stat.wr = 1'b0;
                    end
                end
                CMD_RDX: begin
                    if (req_full) line_d.stat = '0;
                end
                CMD_WR: begin
                    line_d.data       = req_data;
                    line_d.stat.dirty = 1'b1;
                end
                CMD_UPG: begin
                    line_d.stat = '0;
                end
                CMD_WB: begin
                    line_d.data       = req_data;
                    line_d.stat.dirty = 1'b1;
                end
                CMD_FILL: begin
                    line_d.stat = fill_stat;
                    line_d.data = req_data;
                end
                default: ;
            endcase
            flags_d.resp = req_needs_resp && (cmd != CMD_WB) && (cmd != CMD_FILL);
        end
        if (!line_d.stat.vld) line_d.stat = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign sat        = flags_d.sat;
    assign resp_req   = flags_d.resp;
    assign shared_out = flags_d.shr;
    assign nxt_stat   = line_d.stat;
    assign line_stat  = line_q.stat;
    assign line_data  = line_q.data;

    AST_WB_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cmd == 3'd4) |-> !resp_req); // R5

    AST_INVALID_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stat[0] |-> (line_stat[2:1] == 2'b00)); // R9

    AST_FILL_NO_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cmd == 3'd5 && !line_stat[0]) |=> (line_stat == 3'b011 || line_stat == 3'b001)); // R6

    AST_UNSAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !sat) |=> ($stable(line_stat) && $stable(line_data))); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(line_stat) && $stable(line_data))); // R10

    AST_SHARED_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        shared_out |-> (req_valid && req_cmd == 3'd0 && req_full && sat)); // R2

    AST_WB_READ_ONLY_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cmd == 3'd4 && sat && !line_stat[1]) |=> (line_stat == 3'b101)); // R4

    AST_PARTIAL_WB_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_cmd == 3'd4 && !req_full) |-> !sat); // R7

endmodule

// File: tb/tb_coh_line_updater.sv
`timescale 1ns/1ps
module tb_coh_line_updater;

    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [2:0]   req_cmd = '0;
    logic         req_full = 1'b0;
    logic         req_needs_resp = 1'b0;
    logic         fill_excl = 1'b0;
    logic         fill_shared = 1'b0;
    logic [W-1:0] req_data = '0;
    logic         sat, resp_req, shared_out;
    logic [2:0]   nxt_stat, line_stat;
    logic [W-1:0] line_data;

    always #4 clk = ~clk;  // 125 MHz

    coh_line_updater #(.BLK_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_full(req_full), .req_needs_resp(req_needs_resp),
        .fill_excl(fill_excl), .fill_shared(fill_shared), .req_data(req_data),
        .sat(sat), .resp_req(resp_req), .shared_out(shared_out),
        .nxt_stat(nxt_stat), .line_stat(line_stat), .line_data(line_data)
    );

    typedef struct {
        string        tag;
        logic         sat;
        logic         resp;
        logic         shr;
        logic [2:0]   nxt;
        logic [2:0]   cur;
        logic [W-1:0] dat;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails = 0;
    logic [2:0]   m_s = 3'b000;
    logic [W-1:0] m_d = '0;
    bit done = 0;

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // expected values follow the requirement text directly
    task automatic drive(string tag, bit v, logic [2:0] c, bit full, bit nr,
                         bit ex, bit sh, logic [W-1:0] d);
        exp_t e;
        logic [2:0]   ns;
        logic [W-1:0] nd;
        bit s;
        @(negedge clk);
        req_valid = v; req_cmd = c; req_full = full; req_needs_resp = nr;
        fill_excl = ex; fill_shared = sh; req_data = d;
        ns = m_s; nd = m_d; s = 0;
        e.tag = tag; e.cur = m_s; e.dat = m_d; e.shr = 0;
        if (v) begin
            case (c)
                3'd0: s = m_s[0];
                3'd1, 3'd2, 3'd3: s = m_s[0] & m_s[1];
                3'd4: s = m_s[0] & full;
                3'd5: s = 1;
                default: s = 0;
            endcase
            if (s) begin
                case (c)
                    3'd0: if (full) begin ns[1] = 0; e.shr = 1; end
                    3'd1: if (full) ns = 3'b000;
                    3'd2: begin nd = d; ns[2] = 1; end
                    3'd3: ns = 3'b000;
                    3'd4: begin nd = d; ns[2] = 1; end
                    3'd5: begin nd = d; ns = {m_s[0] & m_s[2], ex | ~sh, 1'b1}; end
                    default: ;
                endcase
            end
        end
        e.sat = s;
        e.resp = s & nr & (c != 3'd4) & (c != 3'd5);
        e.nxt = ns;
        q.push_back(e);
        m_s = ns; m_d = nd;
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(e.tag, "sat", W'(sat), W'(e.sat));
                chk(e.tag, "resp_req", W'(resp_req), W'(e.resp));
                chk(e.tag, "shared_out", W'(shared_out), W'(e.shr));
                chk(e.tag, "nxt_stat", W'(nxt_stat), W'(e.nxt));
                chk(e.tag, "line_stat", W'(line_stat), W'(e.cur));
                chk(e.tag, "line_data", line_data, e.dat);
            end
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        chk("R9 reset", "line_stat", W'(line_stat), '0);
        chk("R9 reset", "line_data", line_data, '0);
        rst_n = 1'b1;
        drive("R8 read invalid",          1, 3'd0, 1, 1, 0, 0, 64'h0);
        drive("R6 fill shared",           1, 3'd5, 1, 1, 0, 1, 64'hAAAA_0001);
        drive("R8 write read-only",       1, 3'd2, 0, 1, 0, 0, 64'hDEAD);
        drive("R11 partial read",         1, 3'd0, 0, 1, 0, 0, 64'h0);
        drive("R4 R5 writeback ro",       1, 3'd4, 1, 1, 0, 0, 64'hBBBB_0002);
        drive("R7 partial writeback",     1, 3'd4, 0, 1, 0, 0, 64'hCCCC);
        drive("R2 full read dirty",       1, 3'd0, 1, 1, 0, 0, 64'h0);
        drive("R6 fill excl keeps dirty", 1, 3'd5, 1, 0, 1, 1, 64'hCAFE_0003);
        drive("R2 full read demote",      1, 3'd0, 1, 0, 0, 0, 64'h0);
        drive("R6 fill not shared",       1, 3'd5, 1, 1, 0, 0, 64'hF00D_0004);
        drive("R3 upgrade hit",           1, 3'd3, 0, 1, 0, 0, 64'h0);
        drive("R8 upgrade invalid",       1, 3'd3, 0, 1, 0, 0, 64'h0);
        drive("R6 fill into invalid",     1, 3'd5, 1, 0, 0, 0, 64'h1234_0005);
        drive("R11 write hit",            1, 3'd2, 0, 1, 0, 0, 64'h5555_0006);
        drive("R4 writeback writable",    1, 3'd4, 1, 1, 0, 0, 64'h7777_0007);
        drive("R11 partial excl read",    1, 3'd1, 0, 1, 0, 0, 64'h0);
        drive("R1 full excl read",        1, 3'd1, 1, 1, 0, 0, 64'h0);
        drive("R10 idle",                 0, 3'd5, 1, 1, 1, 0, 64'h9999);
        drive("R10 idle 2",               0, 3'd2, 0, 1, 0, 0, 64'h8888);
        drive("R8 unused code",           1, 3'd6, 1, 1, 0, 0, 64'h0);
        drive("R6 fill shared again",     1, 3'd5, 1, 1, 0, 1, 64'h4444_0008);
        drive("R8 excl read ro",          1, 3'd1, 1, 1, 0, 0, 64'h0);
        drive("R8 unused code 7",         1, 3'd7, 1, 0, 0, 0, 64'h0);
        drive("R10 final state",          0, 3'd0, 0, 0, 0, 0, 64'h0);
        repeat (3) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : watchdog
        #(8 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule